// File: doc/BRIEF.md
# Cascadable Dual Interval Timer

This block is a register-mapped timer built from two 32-bit counters. Each counter has a control/status register and a load register, plus a count register that software can only read. A counter counts up or down, one step per clock cycle, while it is enabled. When it reaches its terminal value it expires. On expiry it either reloads from its load register or wraps around, and it raises an interrupt flag. Software cannot write a count register directly. It places a value in the load register and sets the load bit, which copies that value into the counter and holds it there.

Setting the cascade bit in the first control register joins the two counters into one 64-bit counter. Counter 0 is the low word and counter 1 is the high word. In this mode the run, direction and reload settings all come from control register 0. Counter 1 steps only when the low word wraps. A single synchronous register port gives access: a write strobe with address and data, and a combinational read data output selected by the address. One interrupt output combines both channels.

Top module: `casc_timer`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is 0.
- R2: Byte offsets are 0x00 control 0, 0x04 load 0, 0x08 count 0, 0x10 control 1, 0x14 load 1 and 0x18 count 1. Load registers read back what was written. Writes to a count offset are ignored. A count register changes only by counting or by loading.
- R3: While the load bit (bit 5) of a control register is 1, its counter equals its load register and does not count. Counting resumes once the bit is cleared.
- R4: With the enable bit (bit 7) at 1 and the direction bit (bit 1) at 0, the counter increments by one every clock cycle.
- R5: With the direction bit at 1, an enabled counter decrements by one every clock cycle.
- R6: A counter expires when it steps from all-ones while counting up, or from zero while counting down. On expiry it takes its load value if the auto-reload bit (bit 4) is 1. Otherwise it wraps to zero (up) or all-ones (down).
- R7: Expiry sets the interrupt flag (bit 8). Writing 1 to bit 8 clears the flag, and writing 0 to bit 8 leaves it unchanged.
- R8: `irq_o` is 1 exactly when some channel has both its flag and its interrupt-enable bit (bit 6) at 1.
- R9: When not cascaded, the two channels run independently. Counting on one channel leaves the other channel's count unchanged.
- R10: With the cascade bit (bit 11 of control 0) at 1 and counting up, count 1 increments only in the cycle in which count 0 wraps from all-ones to zero.
- R11: When cascaded and counting down, count 1 decrements only when count 0 wraps from zero to all-ones. The enable and direction bits of control 1 have no effect in this mode.
- R12: When cascaded, the 64-bit value expires when it steps from all-ones (up) or from zero (down). On expiry both words take their load values if auto-reload in control 0 is set, and flag 0 is raised.
- R13: Clearing and then setting the enable bit of control 0 freezes and then resumes the cascaded count. The other control bits read back unchanged.
- R14: Writing 0 to both control registers leaves the timer disabled and not cascaded, with both counts frozen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
Counting is exercised upward and downward from mid-range values. These runs separate the step direction and confirm an exact count of one step per enabled cycle. Starting values just below the all-ones and zero boundaries, with auto-reload on and off, separate a reload from a natural wrap. In cascade mode the low word is preloaded next to its wrap point and control 1 is set to contrary settings. This separates a genuine carry or borrow from an independently counting high word. A full 64-bit rollover is run as well. A free-running cascaded value is read high-low-high, which shows that the two words stay coherent across a carry.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int unsigned ADDR_W = 5;

  // control bit positions
  localparam int unsigned B_DOWN = 1;
  localparam int unsigned B_ARLD = 4;
  localparam int unsigned B_LOAD = 5;
  localparam int unsigned B_IE   = 6;
  localparam int unsigned B_EN   = 7;
  localparam int unsigned B_FLAG = 8;
  localparam int unsigned B_CASC = 11;

  // register select, addr_i[3:2]
  localparam logic [1:0] SEL_CSR = 2'd0;
  localparam logic [1:0] SEL_LR  = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;

  typedef struct packed {
    logic casc;
    logic flag;
    logic en;
    logic ie;
    logic load;
    logic arld;
    logic down;
  } csr_t;
endpackage

// File: rtl/casc_timer_regs.sv
module casc_timer_regs
  import dtmr_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter bit          HAS_CASC = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_csr_i,
  input  logic         wr_lr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         flag_set_i,
  output csr_t         csr_o,
  output logic [W-1:0] lr_o,
  output logic [W-1:0] csr_rd_o
);
  logic         down_q, arld_q, load_q, ie_q, en_q, flag_q, casc_q;
  logic [W-1:0] lr_q;
  logic         flag_clr;

  assign flag_clr = wr_csr_i && wdata_i[B_FLAG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      down_q <= 1'b0;
      arld_q <= 1'b0;
      load_q <= 1'b0;
      ie_q   <= 1'b0;
      en_q   <= 1'b0;
    end else if (wr_csr_i) begin
      down_q <= wdata_i[B_DOWN];
      arld_q <= wdata_i[B_ARLD];
      load_q <= wdata_i[B_LOAD];
      ie_q   <= wdata_i[B_IE];
      en_q   <= wdata_i[B_EN];
    end
  end

  // expiry wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= (flag_q && !flag_clr) || flag_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lr_q <= '0;
    else if (wr_lr_i) lr_q <= wdata_i;
  end

  generate
    if (HAS_CASC) begin : g_casc
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       casc_q <= 1'b0;
        else if (wr_csr_i) casc_q <= wdata_i[B_CASC];
      end
    end else begin : g_no_casc
      assign casc_q = 1'b0;
    end
  endgenerate

  assign csr_o = '{casc: casc_q, flag: flag_q, en: en_q, ie: ie_q,
                   load: load_q, arld: arld_q, down: down_q};
  assign lr_o  = lr_q;

  always_comb begin
    csr_rd_o         = '0;
    csr_rd_o[B_DOWN] = down_q;
    csr_rd_o[B_ARLD] = arld_q;
    csr_rd_o[B_LOAD] = load_q;
    csr_rd_o[B_IE]   = ie_q;
    csr_rd_o[B_EN]   = en_q;
    csr_rd_o[B_FLAG] = flag_q;
    csr_rd_o[B_CASC] = casc_q;
  end

  AST_FLAG_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_clr) |=> flag_q); // R7
endmodule

// File: rtl/casc_timer_cnt.sv
module casc_timer_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         down_i,
  input  logic         reload_i,
  input  logic [W-1:0] lr_i,
  output logic [W-1:0] cnt_o,
  output logic         term_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (load_i)    cnt_q <= lr_i;
    else if (step_i) begin
      if (reload_i)     cnt_q <= lr_i;
      else if (down_i)  cnt_q <= cnt_q - 1'b1;
      else              cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign term_o = down_i ? (cnt_q == '0) : (&cnt_q);

  AST_LOAD_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(lr_i))); // R3
  AST_CNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/casc_timer.sv
module casc_timer
  import dtmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam int unsigned NCH = 2;

  csr_t             csr    [NCH];
  logic [CNT_W-1:0] lr     [NCH];
  logic [CNT_W-1:0] cnt    [NCH];
  logic [CNT_W-1:0] csr_rd [NCH];
  logic [NCH-1:0]   term, step, down, reload, expiry, wr_csr, wr_lr, irq_src;
  logic             casc, word_ok, ch;
  logic [1:0]       sel;

  assign word_ok = (addr_i[1:0] == 2'b00);
  assign ch      = addr_i[4];
  assign sel     = addr_i[3:2];

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_ch
      assign wr_csr[k]  = we_i && word_ok && (ch == k[0]) && (sel == SEL_CSR);
      assign wr_lr[k]   = we_i && word_ok && (ch == k[0]) && (sel == SEL_LR);
      assign irq_src[k] = csr[k].flag && csr[k].ie;

      casc_timer_regs #(.W(CNT_W), .HAS_CASC(k == 0)) i_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_csr_i   (wr_csr[k]),
        .wr_lr_i    (wr_lr[k]),
        .wdata_i    (wdata_i),
        .flag_set_i (expiry[k]),
        .csr_o      (csr[k]),
        .lr_o       (lr[k]),
        .csr_rd_o   (csr_rd[k])
      );

      casc_timer_cnt #(.W(CNT_W)) i_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (csr[k].load),
        .step_i   (step[k]),
        .down_i   (down[k]),
        .reload_i (reload[k]),
        .lr_i     (lr[k]),
        .cnt_o    (cnt[k]),
        .term_o   (term[k])
      );
    end
  endgenerate

  // channel 1 never holds a cascade bit
  assign casc = csr[0].casc || csr[1].casc;

  always_comb begin
    down[0]   = csr[0].down;
    step[0]   = csr[0].en && !csr[0].load && !(casc && csr[1].load);
    if (casc) begin
      down[1]   = csr[0].down;
      step[1]   = step[0] && term[0];
      expiry[0] = step[0] && term[0] && term[1];
      expiry[1] = 1'b0;
      reload[0] = expiry[0] && csr[0].arld;
      reload[1] = expiry[0] && csr[0].arld;
    end else begin
      down[1]   = csr[1].down;
      step[1]   = csr[1].en && !csr[1].load;
      expiry[0] = step[0] && term[0];
      expiry[1] = step[1] && term[1];
      reload[0] = expiry[0] && csr[0].arld;
      reload[1] = expiry[1] && csr[1].arld;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (word_ok) begin
      unique case (sel)
        SEL_CSR: rdata_o = csr_rd[ch];
        SEL_LR:  rdata_o = lr[ch];
        SEL_CNT: rdata_o = cnt[ch];
        default: rdata_o = '0;
      endcase
    end
  end

  assign irq_o = |irq_src;

  AST_FLAG_ON_EXPIRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expiry[0] |=> csr[0].flag); // R12
  AST_HI_CARRY_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (casc && !csr[1].load && !(csr[0].en && !csr[0].load && term[0]))
      |=> $stable(cnt[1])); // R10
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((csr_rd[0][B_FLAG] && csr_rd[0][B_IE]) ||
               (csr_rd[1][B_FLAG] && csr_rd[1][B_IE]))); // R8
endmodule

// File: tb/test_casc_timer.sv
`timescale 1ns/1ps
module test_casc_timer;
  localparam logic [4:0] A_CSR0 = 5'h00, A_LR0 = 5'h04, A_CR0 = 5'h08;
  localparam logic [4:0] A_CSR1 = 5'h10, A_LR1 = 5'h14, A_CR1 = 5'h18;
  localparam logic [31:0] DOWN = 32'h002, ARLD = 32'h010, LOAD = 32'h020;
  localparam logic [31:0] IE = 32'h040, EN = 32'h080, FLAG = 32'h100, CASC = 32'h800;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int vectors = 0;
  int miscompares = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk_i = ~clk_i;

  casc_timer i_casc_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // monitor
  always @(negedge clk_i) begin
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {31'b0, irq_o} : rdata_o;
      vectors++;
      if (act !== it.exp) begin
        miscompares++;
        $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      we_i = 1'b0;
    end
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    @(negedge clk_i);
    we_i = 1'b0; addr_i = a;
    sb_q.push_back('{is_irq: 1'b0, exp: e, tag: tag});
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk_i);
    we_i = 1'b0;
    sb_q.push_back('{is_irq: 1'b1, exp: {31'b0, e}, tag: tag});
  endtask

  task automatic rd_raw(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk_i);
    we_i = 1'b0; addr_i = a;
    #1 v = rdata_o;
  endtask

  task automatic rd64(output logic [63:0] v);
    logic [31:0] h1, lo, h2;
    for (int t = 0; t < 4; t++) begin
      rd_raw(A_CR1, h1);
      rd_raw(A_CR0, lo);
      rd_raw(A_CR1, h2);
      if (h1 == h2) break;
    end
    v = {h2, lo};
  endtask

  task automatic chk(input bit ok, input logic [63:0] act, input logic [63:0] e,
                     input string tag);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, act, e);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [63:0] v0, v1, v2, vs;
    logic [63:0] start;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(A_CSR0, 0, "R1 csr0"); rd(A_LR0, 0, "R1 lr0"); rd(A_CR0, 0, "R1 cr0");
    rd(A_CSR1, 0, "R1 csr1"); rd(A_LR1, 0, "R1 lr1"); rd(A_CR1, 0, "R1 cr1");
    chk_irq(1'b0, "R1 irq");

    // R2 indirect load, count writes ignored
    wr(A_LR0, 100); wr(A_CSR0, LOAD); wr(A_CSR0, 0);
    rd(A_LR0, 100, "R2 lr readback");
    rd(A_CR0, 100, "R2 loaded");
    wr(A_CR0, 55);
    rd(A_CR0, 100, "R2 count write ignored");

    // R3 hold while load bit set
    wr(A_LR0, 200); wr(A_CSR0, LOAD | EN); idle(4);
    rd(A_CR0, 200, "R3 held");
    wr(A_CSR0, EN); idle(4); wr(A_CSR0, 0);
    rd(A_CR0, 205, "R3 resumes after load clear");

    // R4 up
    wr(A_CSR0, EN); idle(9); wr(A_CSR0, 0);
    rd(A_CR0, 215, "R4 up ten steps");

    // R5 down
    wr(A_CSR0, EN | DOWN); idle(14); wr(A_CSR0, 0);
    rd(A_CR0, 200, "R5 down fifteen steps");

    // R6 up wrap without reload, R7/R8 flag and irq
    wr(A_LR0, 32'hFFFF_FFFE); wr(A_CSR0, LOAD); wr(A_CSR0, 0);
    wr(A_CSR0, EN); idle(2); wr(A_CSR0, 0);
    rd(A_CR0, 1, "R6 up wrap to zero");
    rd(A_CSR0, FLAG, "R7 flag set on expiry");
    chk_irq(1'b0, "R8 flag without enable");
    wr(A_CSR0, IE);
    rd(A_CSR0, IE | FLAG, "R7 write 0 keeps flag");
    chk_irq(1'b1, "R8 flag with enable");
    wr(A_CSR0, FLAG);
    rd(A_CSR0, 0, "R7 write 1 clears flag");
    chk_irq(1'b0, "R8 after clear");

    // R6 up with reload
    wr(A_LR0, 32'hFFFF_FFFD); wr(A_CSR0, LOAD); wr(A_CSR0, 0);
    wr(A_CSR0, EN | ARLD); idle(3); wr(A_CSR0, 0);
    rd(A_CR0, 32'hFFFF_FFFE, "R6 up reload");
    wr(A_CSR0, FLAG);

    // R6 down with reload
    wr(A_LR0, 2); wr(A_CSR0, LOAD); wr(A_CSR0, 0);
    wr(A_CSR0, EN | DOWN | ARLD); idle(3); wr(A_CSR0, 0);
    rd(A_CR0, 1, "R6 down reload");
    rd(A_CSR0, FLAG, "R7 down expiry flag");
    wr(A_CSR0, FLAG);

    // R9 independent channel 1
    wr(A_LR1, 50); wr(A_CSR1, LOAD); wr(A_CSR1, 0);
    wr(A_CSR1, EN | DOWN); idle(5); wr(A_CSR1, 0);
    rd(A_CR1, 44, "R9 ch1 counts");
    rd(A_CR0, 1, "R9 ch0 untouched");
    wr(A_LR1, 0); wr(A_CSR1, LOAD); wr(A_CSR1, 0);
    wr(A_CSR1, EN | DOWN | IE); wr(A_CSR1, IE);
    rd(A_CR1, 32'hFFFF_FFFF, "R6 ch1 down wrap");
    chk_irq(1'b1, "R8 ch1 irq");
    rd(A_CSR1, IE | FLAG, "R7 ch1 flag");
    wr(A_CSR1, FLAG);
    chk_irq(1'b0, "R8 ch1 cleared");

    // R10 cascade carry, ch1 bits contrary
    wr(A_LR0, 32'hFFFF_FFFE); wr(A_LR1, 5);
    wr(A_CSR0, LOAD); wr(A_CSR1, LOAD);
    wr(A_CSR0, CASC); wr(A_CSR1, EN | DOWN);
    wr(A_CSR0, CASC | EN); idle(2); wr(A_CSR0, CASC);
    rd(A_CR0, 1, "R10 low wrapped");
    rd(A_CR1, 6, "R10 high carried");

    // R11 cascade borrow
    wr(A_CSR0, CASC | EN | DOWN); idle(2); wr(A_CSR0, CASC);
    rd(A_CR0, 32'hFFFF_FFFE, "R11 low borrowed");
    rd(A_CR1, 5, "R11 high decremented");

    // R12 64-bit expiry with reload
    wr(A_LR0, 32'hFFFF_FFFF); wr(A_LR1, 32'hFFFF_FFFF);
    wr(A_CSR0, CASC | LOAD); wr(A_CSR1, LOAD); wr(A_CSR1, 0); wr(A_CSR0, CASC);
    wr(A_LR0, 7); wr(A_LR1, 9);
    wr(A_CSR0, CASC | EN | ARLD | IE); wr(A_CSR0, CASC | IE);
    rd(A_CR0, 7, "R12 low reloaded");
    rd(A_CR1, 9, "R12 high reloaded");
    chk_irq(1'b1, "R12 irq");
    rd(A_CSR0, CASC | IE | FLAG, "R12 flag0");
    wr(A_CSR0, CASC | FLAG);
    rd(A_CSR0, CASC, "R12 flag cleared");

    // R13 stop and resume
    wr(A_CSR0, CASC | ARLD | EN); idle(3); wr(A_CSR0, CASC | ARLD);
    idle(3);
    rd(A_CR0, 11, "R13 frozen");
    rd(A_CSR0, CASC | ARLD, "R13 bits intact");
    wr(A_CSR0, CASC | ARLD | EN); idle(1); wr(A_CSR0, CASC | ARLD);
    rd(A_CR0, 13, "R13 resumed");
    rd(A_CR1, 9, "R13 high steady");

    // R10 coherent 64-bit read across a carry
    start = {32'd2, 32'hFFFF_FFF0};
    wr(A_LR0, start[31:0]); wr(A_LR1, start[63:32]);
    wr(A_CSR0, CASC | LOAD); wr(A_CSR1, LOAD); wr(A_CSR1, 0);
    wr(A_CSR0, CASC | EN);
    rd64(v0); idle(4); rd64(v1); idle(4); rd64(v2);
    wr(A_CSR0, CASC);
    chk(v0 > start && v0 < start + 64, v0, start, "R10 hi-lo-hi first");
    chk(v1 > v0 && v1 < start + 64, v1, v0, "R10 hi-lo-hi second");
    chk(v2 > v1 && v2 < start + 64, v2, v1, "R10 hi-lo-hi third");
    chk(v2[63:32] == 32'd3, v2, {32'd3, v2[31:0]}, "R10 carry seen");
    rd64(vs); idle(3); rd64(v0);
    chk(v0 == vs, v0, vs, "R13 cascaded count frozen");

    // R14 zero both control registers
    wr(A_CSR0, 0); wr(A_CSR1, 0);
    rd(A_CSR0, 0, "R14 csr0 idle");
    rd(A_CSR1, 0, "R14 csr1 idle");
    idle(3);
    rd(A_CR0, vs[31:0], "R14 low frozen");
    wr(A_CSR1, EN); wr(A_CSR1, 0);
    rd(A_CR1, vs[63:32] + 1, "R14 high counts alone");
    rd(A_CR0, vs[31:0], "R14 not cascaded");

    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule